// File: doc/BRIEF.md
# Fixed-Point Leaky Integrate-and-Fire Step Unit

This block advances one spiking neuron by a single discrete time step, using only integer arithmetic. Each request carries the neuron's membrane state from the previous step, the signed sum of weighted input spikes that arrived for this step, and the neuron's parameters: a decay multiplier with its right-shift amount, a left-shift amount that converts weight scaling to state scaling, a firing threshold already expressed in state scaling, and a refractory length. The block returns the new membrane state, a spike flag and the new value of the neuron's refractory countdown.

The leak is applied by multiplying the old state by the unsigned decay multiplier at double width and then shifting arithmetically right. The scaled input is added, and the sum is clamped to the signed state range. If the clamped value reaches the threshold, the neuron fires: its state returns to zero and its countdown is loaded with the refractory length. While a countdown is running, the neuron is held at zero, cannot fire, ignores its input, and the countdown drops by one each step. A surrounding scheduler stores the per-neuron state and countdown between steps. It issues one request per neuron per step through a valid/ready pair. The result is registered and appears one clock later.

Top module: `lif_step_unit`

## Requirements
- R1: With no input and no firing, the new state is (state × decay) shifted arithmetically right by the decay shift, computed at 64 bits, so negative values round toward minus infinity.
- R2: The signed input, shifted left by the scale shift (0 to 31), is added to the leaked state.
- R3: The sum saturates to the signed 32-bit range: above 2147483647 it becomes 2147483647, below -2147483648 it becomes -2147483648. It never wraps.
- R4: When the countdown input is 0 and the saturated sum is greater than or equal to the signed threshold, the spike output is 1 and the new state is 0. Equality fires.
- R5: On a spike, the countdown output equals the refractory length input.
- R6: When the countdown input is nonzero, the new state is 0, the spike output is 0, the countdown output is the countdown input minus 1, and the input, decay and threshold have no effect.
- R7: When the countdown input is 0 and the neuron does not fire, the spike output is 0, the countdown output is 0, and the new state is the saturated sum.
- R8: in_ready is always 1. out_valid is 1 exactly in the cycle after a cycle with in_valid at 1. All result outputs update only on such a launch and otherwise hold their values.
- R9: After reset, out_valid, state_out, spike_out and refr_out are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Launches an update in this cycle |
| in_ready | output | 1 | Always 1; the unit accepts a request every cycle |
| state_in | input | 32 | Previous membrane state, signed |
| syn_in | input | 32 | Summed synaptic input for this step, signed |
| decay_k | input | 16 | Decay multiplier, unsigned |
| decay_shift | input | 5 | Right shift applied after the multiply |
| scale_shift | input | 5 | Left shift applied to the input |
| threshold | input | 32 | Firing threshold in state scaling, signed |
| refr_len | input | 8 | Refractory length loaded on a spike |
| refr_in | input | 8 | Current refractory countdown |
| out_valid | output | 1 | Result valid |
| state_out | output | 32 | New membrane state, signed |
| spike_out | output | 1 | Spike flag |
| refr_out | output | 8 | New refractory countdown |

## Verification
The bench uses the default widths: a 32-bit state, a 16-bit decay multiplier, 5-bit shifts and an 8-bit countdown. With these widths a state near either signed limit, combined with a 31-bit shift, drives the adder into both saturation rails. A 16-bit multiplier at full scale combined with a 31-bit right shift shows that negative leak rounds downward. The 8-bit countdown makes it possible to check both the final refractory step (countdown 1) and a reload with a new length.

// File: rtl/lif_pkg.sv
package lif_pkg;

    // Which branch of the step update produced the result
    typedef enum logic [1:0] {
        PH_INTEGRATE = 2'd0,
        PH_FIRE      = 2'd1,
        PH_REFRACT   = 2'd2
    } lif_phase_e;

endpackage

// File: rtl/lif_leak.sv
module lif_leak #(
    parameter int STATE_W = 32,
    parameter int DECAY_W = 16,
    parameter int SHIFT_W = 5,
    parameter int WIDE_W  = 2 * STATE_W
) (
    input  logic signed [STATE_W-1:0] state_i,
    input  logic        [DECAY_W-1:0] decay_i,
    input  logic        [SHIFT_W-1:0] shift_i,
    output logic signed [WIDE_W-1:0]  leak_o
);
    logic signed [WIDE_W-1:0] st_x;
    logic signed [WIDE_W-1:0] k_x;
    logic signed [WIDE_W-1:0] prod;

    always_comb begin
        st_x   = WIDE_W'(state_i);
        k_x    = WIDE_W'({1'b0, decay_i});
        prod   = st_x * k_x;
        leak_o = prod >>> shift_i;
    end
endmodule

// File: rtl/lif_scale.sv
module lif_scale #(
    parameter int STATE_W = 32,
    parameter int SHIFT_W = 5,
    parameter int WIDE_W  = 2 * STATE_W
) (
    input  logic signed [STATE_W-1:0] syn_i,
    input  logic        [SHIFT_W-1:0] shift_i,
    output logic signed [WIDE_W-1:0]  scaled_o
);
    logic signed [WIDE_W-1:0] syn_x;

    always_comb begin
        syn_x    = WIDE_W'(syn_i);
        scaled_o = syn_x <<< shift_i;
    end
endmodule

// File: rtl/lif_fire.sv
module lif_fire
    import lif_pkg::*;
#(
    parameter int STATE_W = 32,
    parameter int REFR_W  = 8,
    parameter int WIDE_W  = 2 * STATE_W
) (
    input  logic signed [WIDE_W-1:0]  leak_i,
    input  logic signed [WIDE_W-1:0]  scaled_i,
    input  logic signed [STATE_W-1:0] thresh_i,
    input  logic        [REFR_W-1:0]  refr_i,
    input  logic        [REFR_W-1:0]  refr_len_i,
    output logic signed [STATE_W-1:0] state_o,
    output logic                      spike_o,
    output logic        [REFR_W-1:0]  refr_o,
    output lif_phase_e                phase_o
);
    localparam int SUM_W = WIDE_W + 1;
    localparam int PAD_W = SUM_W - STATE_W + 1;
    localparam logic signed [SUM_W-1:0] SAT_HI = {{PAD_W{1'b0}}, {(STATE_W-1){1'b1}}};
    localparam logic signed [SUM_W-1:0] SAT_LO = {{PAD_W{1'b1}}, {(STATE_W-1){1'b0}}};
    localparam logic signed [STATE_W-1:0] ST_MAX = {1'b0, {(STATE_W-1){1'b1}}};
    localparam logic signed [STATE_W-1:0] ST_MIN = {1'b1, {(STATE_W-1){1'b0}}};
    localparam logic [REFR_W-1:0] REFR_ONE = REFR_W'(1);

    logic signed [SUM_W-1:0]   sum;
    logic signed [STATE_W-1:0] sat;

    always_comb begin
        sum = {leak_i[WIDE_W-1], leak_i} + {scaled_i[WIDE_W-1], scaled_i};
        if (sum > SAT_HI)      sat = ST_MAX;
        else if (sum < SAT_LO) sat = ST_MIN;
        else                   sat = sum[STATE_W-1:0];

        if (refr_i != '0) begin
            phase_o = PH_REFRACT;
            state_o = '0;
            spike_o = 1'b0;
            refr_o  = refr_i - REFR_ONE;
        end else if (sat >= thresh_i) begin
            phase_o = PH_FIRE;
            state_o = '0;
            spike_o = 1'b1;
            refr_o  = refr_len_i;
        end else begin
            phase_o = PH_INTEGRATE;
            state_o = sat;
            spike_o = 1'b0;
            refr_o  = '0;
        end
    end
endmodule

// File: rtl/lif_step_unit.sv
module lif_step_unit
    import lif_pkg::*;
#(
    parameter int STATE_W = 32,
    parameter int DECAY_W = 16,
    parameter int SHIFT_W = 5,
    parameter int REFR_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    output logic                      in_ready,
    input  logic signed [STATE_W-1:0] state_in,
    input  logic signed [STATE_W-1:0] syn_in,
    input  logic        [DECAY_W-1:0] decay_k,
    input  logic        [SHIFT_W-1:0] decay_shift,
    input  logic        [SHIFT_W-1:0] scale_shift,
    input  logic signed [STATE_W-1:0] threshold,
    input  logic        [REFR_W-1:0]  refr_len,
    input  logic        [REFR_W-1:0]  refr_in,
    output logic                      out_valid,
    output logic signed [STATE_W-1:0] state_out,
    output logic                      spike_out,
    output logic        [REFR_W-1:0]  refr_out
);
    localparam int WIDE_W = 2 * STATE_W;

    typedef struct packed {
        logic                      valid;
        logic signed [STATE_W-1:0] state;
        logic                      spike;
        logic        [REFR_W-1:0]  refr;
        lif_phase_e                phase;
    } res_t;

    logic signed [WIDE_W-1:0]  leak_w;
    logic signed [WIDE_W-1:0]  scaled_w;
    logic signed [STATE_W-1:0] nxt_state;
    logic                      nxt_spike;
    logic        [REFR_W-1:0]  nxt_refr;
    lif_phase_e                nxt_phase;
    logic                      launch;
    res_t                      res_d, res_q;

    lif_leak #(
        .STATE_W(STATE_W), .DECAY_W(DECAY_W), .SHIFT_W(SHIFT_W), .WIDE_W(WIDE_W)
    ) u_leak (
        .state_i(state_in), .decay_i(decay_k), .shift_i(decay_shift), .leak_o(leak_w)
    );

    lif_scale #(
        .STATE_W(STATE_W), .SHIFT_W(SHIFT_W), .WIDE_W(WIDE_W)
    ) u_scale (
        .syn_i(syn_in), .shift_i(scale_shift), .scaled_o(scaled_w)
    );

    lif_fire #(
        .STATE_W(STATE_W), .REFR_W(REFR_W), .WIDE_W(WIDE_W)
    ) u_fire (
        .leak_i(leak_w), .scaled_i(scaled_w), .thresh_i(threshold),
        .refr_i(refr_in), .refr_len_i(refr_len),
        .state_o(nxt_state), .spike_o(nxt_spike), .refr_o(nxt_refr), .phase_o(nxt_phase)
    );

    assign in_ready = 1'b1;
    assign launch   = in_valid & in_ready;

    always_comb begin
        res_d       = res_q;
        res_d.valid = launch;
        if (launch) begin
            res_d.state = nxt_state;
            res_d.spike = nxt_spike;
            res_d.refr  = nxt_refr;
            res_d.phase = nxt_phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '{valid: 1'b0, state: '0, spike: 1'b0, refr: '0, phase: PH_INTEGRATE};
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign state_out = res_q.state;
    assign spike_out = res_q.spike;
    assign refr_out  = res_q.refr;
endmodule

// File: rtl/lif_step_unit_chk.sv
module lif_step_unit_chk #(
    parameter int STATE_W = 32,
    parameter int REFR_W  = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      in_valid,
    input logic                      in_ready,
    input logic        [REFR_W-1:0]  refr_in,
    input logic        [REFR_W-1:0]  refr_len,
    input logic                      out_valid,
    input logic signed [STATE_W-1:0] state_out,
    input logic                      spike_out,
    input logic        [REFR_W-1:0]  refr_out
);
    localparam logic [REFR_W-1:0] ONE = REFR_W'(1);

    // R8
    launch_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    // R8
    idle_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(state_out) && $stable(refr_out) && $stable(spike_out)));

    // R6
    refract_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && refr_in != '0) |=>
            (state_out == '0 && !spike_out && refr_out == $past(refr_in) - ONE));

    // R4
    fire_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && spike_out) |-> state_out == '0);

    // R5
    fire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && refr_in == '0) |=> (spike_out ? refr_out == $past(refr_len) : refr_out == '0));

    // R8
    ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n) in_ready);
endmodule

bind lif_step_unit lif_step_unit_chk #(.STATE_W(STATE_W), .REFR_W(REFR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .refr_in(refr_in), .refr_len(refr_len), .out_valid(out_valid),
    .state_out(state_out), .spike_out(spike_out), .refr_out(refr_out)
);

// File: tb/lif_step_unit_test.sv
`timescale 1ns/1ps
module lif_step_unit_test;
    localparam int STATE_W = 32;
    localparam int DECAY_W = 16;
    localparam int SHIFT_W = 5;
    localparam int REFR_W  = 8;
    localparam int NVEC    = 12;

    typedef struct packed {
        logic [31:0] st;
        logic [31:0] syn;
        logic [15:0] k;
        logic [4:0]  g;
        logic [4:0]  s;
        logic [31:0] thr;
        logic [7:0]  rl;
        logic [7:0]  rin;
        logic [31:0] e_st;
        logic        e_sp;
        logic [7:0]  e_rf;
        logic [7:0]  req;
    } vec_t;

    localparam logic [31:0] TMAX = 32'h7FFF_FFFF;

    localparam vec_t VEC [NVEC] = '{
        // R1 positive leak: 1000*900>>10 = 878
        '{32'd1000, 32'd0, 16'd900, 5'd10, 5'd0, TMAX, 8'd5, 8'd0, 32'd878, 1'b0, 8'd0, 8'd1},
        // R1 negative leak floors: -900000>>>10 = -879
        '{-32'sd1000, 32'd0, 16'd900, 5'd10, 5'd0, TMAX, 8'd5, 8'd0, -32'sd879, 1'b0, 8'd0, 8'd1},
        // R1 wide shift: -65535>>>31 = -1
        '{-32'sd1, 32'd0, 16'hFFFF, 5'd31, 5'd0, TMAX, 8'd5, 8'd0, -32'sd1, 1'b0, 8'd0, 8'd1},
        // R2 input 3<<4 = 48
        '{32'd0, 32'd3, 16'd900, 5'd10, 5'd0 + 5'd4, TMAX, 8'd5, 8'd0, 32'd48, 1'b0, 8'd0, 8'd2},
        // R2 negative input: 100 + (-2<<3) = 84
        '{32'd100, -32'sd2, 16'd1024, 5'd10, 5'd3, TMAX, 8'd5, 8'd0, 32'd84, 1'b0, 8'd0, 8'd2},
        // R4 equality fires, R5 reload 7
        '{32'd0, 32'd5, 16'd1, 5'd0, 5'd2, 32'd20, 8'd7, 8'd0, 32'd0, 1'b1, 8'd7, 8'd4},
        // R7 one below threshold
        '{32'd0, 32'd5, 16'd1, 5'd0, 5'd2, 32'd21, 8'd7, 8'd0, 32'd20, 1'b0, 8'd0, 8'd7},
        // R3 positive rail reached (wrap would not fire)
        '{32'h7FFF_FFF0, 32'd1, 16'd1, 5'd0, 5'd5, TMAX, 8'd3, 8'd0, 32'd0, 1'b1, 8'd3, 8'd3},
        // R3 negative rail
        '{32'h8000_0010, -32'sd1, 16'd1, 5'd0, 5'd5, 32'd0, 8'd3, 8'd0, 32'h8000_0000, 1'b0, 8'd0, 8'd3},
        // R6 refractory, input ignored
        '{32'd5000, 32'd1000, 16'd1, 5'd0, 5'd10, 32'd1, 8'd9, 8'd4, 32'd0, 1'b0, 8'd3, 8'd6},
        // R6 last refractory step
        '{32'd5000, 32'h0FFF_FFFF, 16'd1, 5'd0, 5'd31, 32'd1, 8'd9, 8'd1, 32'd0, 1'b0, 8'd0, 8'd6},
        // R4 negative threshold equality, R5 reload 2
        '{-32'sd50, 32'd0, 16'd1, 5'd0, 5'd0, -32'sd50, 8'd2, 8'd0, 32'd0, 1'b1, 8'd2, 8'd5}
    };

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      in_valid = 1'b0;
    logic                      in_ready;
    logic signed [STATE_W-1:0] state_in = '0;
    logic signed [STATE_W-1:0] syn_in = '0;
    logic        [DECAY_W-1:0] decay_k = '0;
    logic        [SHIFT_W-1:0] decay_shift = '0;
    logic        [SHIFT_W-1:0] scale_shift = '0;
    logic signed [STATE_W-1:0] threshold = '0;
    logic        [REFR_W-1:0]  refr_len = '0;
    logic        [REFR_W-1:0]  refr_in = '0;
    logic                      out_valid;
    logic signed [STATE_W-1:0] state_out;
    logic                      spike_out;
    logic        [REFR_W-1:0]  refr_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lif_step_unit #(
        .STATE_W(STATE_W), .DECAY_W(DECAY_W), .SHIFT_W(SHIFT_W), .REFR_W(REFR_W)
    ) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .state_in(state_in), .syn_in(syn_in), .decay_k(decay_k),
        .decay_shift(decay_shift), .scale_shift(scale_shift), .threshold(threshold),
        .refr_len(refr_len), .refr_in(refr_in), .out_valid(out_valid),
        .state_out(state_out), .spike_out(spike_out), .refr_out(refr_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        state_in = v.st; syn_in = v.syn; decay_k = v.k; decay_shift = v.g;
        scale_shift = v.s; threshold = v.thr; refr_len = v.rl; refr_in = v.rin;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9", "out_valid", 32'(out_valid), 32'd0);
        check("R9", "state_out", state_out, 32'd0);
        check("R9", "spike_out", 32'(spike_out), 32'd0);
        check("R9", "refr_out", 32'(refr_out), 32'd0);
        check("R8", "in_ready", 32'(in_ready), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", "no launch no valid", 32'(out_valid), 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i]);
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d valid", i), 32'(out_valid), 32'd1);
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d state", i), state_out, VEC[i].e_st);
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d spike", i), 32'(spike_out), 32'(VEC[i].e_sp));
            check($sformatf("R%0d", VEC[i].req), $sformatf("vec%0d refr", i), 32'(refr_out), 32'(VEC[i].e_rf));
        end

        // R8 outputs hold without a launch even when inputs change
        syn_in = 32'd77; refr_in = 8'd0; threshold = TMAX; state_in = 32'd9;
        decay_k = 16'd1; decay_shift = '0; scale_shift = '0;
        @(negedge clk);
        check("R8", "idle valid", 32'(out_valid), 32'd0);
        check("R8", "idle state hold", state_out, 32'd0);
        check("R8", "idle spike hold", 32'(spike_out), 32'd1);
        check("R8", "idle refr hold", 32'(refr_out), 32'd2);

        // R8 back-to-back launches each give a result the next cycle
        @(negedge clk);
        in_valid = 1'b1;
        @(negedge clk);
        check("R8", "b2b first state", state_out, 32'd86);
        syn_in = 32'd1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8", "b2b second valid", 32'(out_valid), 32'd1);
        check("R7", "b2b second state", state_out, 32'd10);
        check("R7", "b2b refr", 32'(refr_out), 32'd0);

        // R9 reset in mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R9", "re-reset state", state_out, 32'd0);
        check("R9", "re-reset valid", 32'(out_valid), 32'd0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule